// File: doc/BRIEF.md
# Boot-Block Flash Write Controller

This block is the command and sequencing logic for one byte-wide flash die with a 1 MB address space. The space is split into erase blocks of uneven size. A host issues bus write cycles that carry command bytes, addresses and data. The controller decodes the target address into its erase block and applies the hardware lock on the boot block. It then starts an automated program or erase and holds a busy period that is counted in clock cycles. Progress is reported through a status byte. The storage array itself sits outside the block. It receives a one-cycle program strobe with address and data, or a one-cycle erase strobe with block base and block size.

The map has four kinds of block: one 16 KB boot block, two 8 KB parameter blocks, one 96 KB main block and seven 128 KB main blocks. A configuration input mirrors the whole map, which moves the boot block from the lowest addresses to the highest. An erase of a boot or parameter block takes one busy time and an erase of a main block takes a longer one. A program takes a much shorter busy time. All three times are parameters. The supply-valid input is watched throughout the busy period. A low level on the reset/power-down input abandons any operation in progress.

Top module: `bbflash_ctrl`

## Requirements
- R1: With `top_boot`=0, block boundaries are: boot 0x00000–0x03FFF, parameter 0x04000–0x05FFF and 0x06000–0x07FFF, main 0x08000–0x1FFFF, and 128 KB main blocks on each 0x20000 boundary from 0x20000 up. An erase reports that block's lowest address on `erase_base` and its byte count on `erase_size`.
- R2: With `top_boot`=1 the map is mirrored. An address A falls in the block whose bottom-map position holds 0xFFFFF−A, and `erase_base` is the lowest address of the mirrored block.
- R3: A write of 0x20 followed by a write of 0xD0 gives exactly one single-cycle `erase_stb` pulse, for the block holding the second write's address. A program pulse and an erase pulse never occur in the same cycle.
- R4: After reset, reads select array data (`rd_status`=0) and `status` is 0x80. After any program or erase sequence, `rd_status` stays 1 until a 0xFF write. A 0x70 write also selects status. `status` bit 7 is 1 when the controller is not busy.
- R5: A program or erase aimed at the boot block is carried out only if `wp_hi` or `rp_unlock` is 1. If it is refused, no strobe is sent and status bit 1 is set.
- R6: The busy time, counted as cycles with status bit 7 at 0 starting in the strobe cycle, is `T_PROG` for a program. For an erase it is `T_ERS_SMALL` for a boot or parameter block and `T_ERS_MAIN` for a main block.
- R7: If `vpp_ok` is 0 when an operation would start, the operation is refused with status bit 3 set. If `vpp_ok` falls during the busy period, the operation is abandoned in the next cycle, the controller becomes ready and status bit 3 is set.
- R8: While `rp_n` is 0, the next clock returns the controller to array-read mode with `status`=0x80 and no strobes, abandoning any operation.
- R9: A second erase cycle carrying any byte other than 0xD0 sends no erase and sets status bit 5.
- R10: A 0x50 write while idle clears status bits 5, 4, 3 and 1.
- R11: While busy, command writes are ignored and `rd_status` stays 1. The busy time and any later mode are unchanged.
- R12: The second program cycle (after 0x40) sends `prog_data` = write data AND `arr_rdata`, with `prog_addr` = write address. It sets status bit 4 when the write data asks for any 0 to become 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Bus write address |
| wr_data | input | 8 | Bus write data or command byte |
| arr_rdata | input | 8 | Current array contents at `wr_addr` |
| top_boot | input | 1 | 1 mirrors the map so the boot block is at the top |
| wp_hi | input | 1 | Write-protect input high, unlocks the boot block |
| rp_n | input | 1 | Reset/power-down, active low, sampled by clock |
| rp_unlock | input | 1 | Reset input at its high-voltage unlock level |
| vpp_ok | input | 1 | Program/erase supply above lockout |
| prog_stb | output | 1 | One-cycle program strobe to the array |
| prog_addr | output | 20 | Program address |
| prog_data | output | 8 | Program data (clear-only) |
| erase_stb | output | 1 | One-cycle block erase strobe |
| erase_base | output | 20 | Lowest address of the erased block |
| erase_size | output | 20 | Byte count of the erased block |
| rd_status | output | 1 | 1 when reads must return `status` |
| status | output | 8 | Status byte |

## Verification
The bench erases random addresses with the map randomly mirrored and compares block base, size and busy length against a block table it builds itself. A swapped boot/parameter/main decode or a wrong busy time would show up there. Directed cases probe the boot block with both unlock paths and with none. A lock that ignored one unlock input would refuse a valid erase, and a missing lock would strobe a protected block. Supply loss is tested both at the start and midway through a main erase. A controller that kept counting would stay busy and never flag bit 3. Other cases cover commands written while busy, which must not cut the busy time short or start a program, and a bad erase confirm, which must not erase. Random program data against random array contents catches a design that passes bits from 0 to 1 or misses the program-error flag.

// File: rtl/bbflash_ctrl.sv
module bbflash_ctrl #(
  parameter int T_PROG      = 300,
  parameter int T_ERS_SMALL = 15_000_000,
  parameter int T_ERS_MAIN  = 30_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [19:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  arr_rdata,
  input  logic        top_boot,
  input  logic        wp_hi,
  input  logic        rp_n,
  input  logic        rp_unlock,
  input  logic        vpp_ok,
  output logic        prog_stb,
  output logic [19:0] prog_addr,
  output logic [7:0]  prog_data,
  output logic        erase_stb,
  output logic [19:0] erase_base,
  output logic [19:0] erase_size,
  output logic        rd_status,
  output logic [7:0]  status
);
  localparam int TMAX = (T_PROG > T_ERS_SMALL) ?
                        ((T_PROG > T_ERS_MAIN) ? T_PROG : T_ERS_MAIN) :
                        ((T_ERS_SMALL > T_ERS_MAIN) ? T_ERS_SMALL : T_ERS_MAIN);
  localparam int CW = $clog2(TMAX + 1);

  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_ERASE = 8'h20;
  localparam logic [7:0] C_CONF  = 8'hD0;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_ARRAY = 8'hFF;
  localparam logic [7:0] C_CLR   = 8'h50;

  typedef enum logic [1:0] {S_IDLE, S_PSET, S_ESET, S_BUSY} st_t;

  st_t           st;
  logic          sr_mode;
  logic [CW-1:0] cnt;
  logic          e_err, p_err, v_err, l_err;

  logic [19:0] m, bb, bsz, blk_base;
  logic        is_boot, is_main, locked, bad_bits;

  assign m = top_boot ? ~wr_addr : wr_addr;

  always_comb begin
    is_boot = 1'b0;
    is_main = 1'b0;
    if (m < 20'h04000) begin
      bb = 20'h00000; bsz = 20'h04000; is_boot = 1'b1;
    end else if (m < 20'h06000) begin
      bb = 20'h04000; bsz = 20'h02000;
    end else if (m < 20'h08000) begin
      bb = 20'h06000; bsz = 20'h02000;
    end else if (m < 20'h20000) begin
      bb = 20'h08000; bsz = 20'h18000; is_main = 1'b1;
    end else begin
      bb = {m[19:17], 17'd0}; bsz = 20'h20000; is_main = 1'b1;
    end
  end

  assign blk_base  = top_boot ? ~(bb + bsz - 20'd1) : bb;
  assign locked    = is_boot && !(wp_hi || rp_unlock);
  assign bad_bits  = |(wr_data & ~arr_rdata);
  assign rd_status = sr_mode || (st == S_BUSY);
  assign status    = {st != S_BUSY, 1'b0, e_err, p_err, v_err, 1'b0, l_err, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sr_mode <= 1'b0; cnt <= '0;
      e_err <= 1'b0; p_err <= 1'b0; v_err <= 1'b0; l_err <= 1'b0;
      prog_stb <= 1'b0; prog_addr <= '0; prog_data <= '0;
      erase_stb <= 1'b0; erase_base <= '0; erase_size <= '0;
    end else begin
      prog_stb  <= 1'b0;
      erase_stb <= 1'b0;
      if (!rp_n) begin
        st <= S_IDLE; sr_mode <= 1'b0; cnt <= '0;
        e_err <= 1'b0; p_err <= 1'b0; v_err <= 1'b0; l_err <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (wr_en) begin
            case (wr_data)
              C_PROG:  st <= S_PSET;
              C_ERASE: st <= S_ESET;
              C_STAT:  sr_mode <= 1'b1;
              C_ARRAY: sr_mode <= 1'b0;
              C_CLR:   begin e_err <= 1'b0; p_err <= 1'b0; v_err <= 1'b0; l_err <= 1'b0; end
              default: ;
            endcase
          end
          S_PSET: if (wr_en) begin
            sr_mode <= 1'b1;
            st      <= S_IDLE;
            if (locked) l_err <= 1'b1;
            else if (!vpp_ok) v_err <= 1'b1;
            else begin
              prog_stb  <= 1'b1;
              prog_addr <= wr_addr;
              prog_data <= wr_data & arr_rdata;
              if (bad_bits) p_err <= 1'b1;
              cnt <= CW'(T_PROG - 1);
              st  <= S_BUSY;
            end
          end
          S_ESET: if (wr_en) begin
            sr_mode <= 1'b1;
            st      <= S_IDLE;
            if (wr_data != C_CONF) e_err <= 1'b1;
            else if (locked) l_err <= 1'b1;
            else if (!vpp_ok) v_err <= 1'b1;
            else begin
              erase_stb  <= 1'b1;
              erase_base <= blk_base;
              erase_size <= bsz;
              cnt <= is_main ? CW'(T_ERS_MAIN - 1) : CW'(T_ERS_SMALL - 1);
              st  <= S_BUSY;
            end
          end
          S_BUSY: begin
            if (!vpp_ok) begin
              v_err <= 1'b1;
              st    <= S_IDLE;
            end else if (cnt == '0) st <= S_IDLE;
            else cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module bbflash_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rp_n,
  input logic        wp_hi,
  input logic        rp_unlock,
  input logic        vpp_ok,
  input logic [7:0]  arr_rdata,
  input logic        prog_stb,
  input logic [7:0]  prog_data,
  input logic        erase_stb,
  input logic [19:0] erase_base,
  input logic [19:0] erase_size,
  input logic        rd_status,
  input logic [7:0]  status
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_stb && erase_stb));

  p_block_in_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |-> ({1'b0, erase_base} + {1'b0, erase_size} <= 21'h100000));

  p_boot_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stb && erase_size == 20'h04000) |-> $past(wp_hi || rp_unlock));

  p_clear_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> ((prog_data & ~$past(arr_rdata)) == 8'h00));

  p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || erase_stb) |-> (!status[7] && rd_status));

  p_vpp_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] && !vpp_ok && rp_n) |=> (status[7] && status[3]));

  p_powerdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (status == 8'h80 && !rd_status && !prog_stb && !erase_stb));
endmodule

bind bbflash_ctrl bbflash_ctrl_chk u_chk (.*);

// File: tb/bbflash_ctrl_test.sv
module bbflash_ctrl_test;
  localparam int TP = 12, TES = 40, TEM = 70;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0, arr_rdata = 8'hFF;
  logic top_boot = 0, wp_hi = 1, rp_n = 1, rp_unlock = 0, vpp_ok = 1;
  logic prog_stb, erase_stb, rd_status;
  logic [19:0] prog_addr, erase_base, erase_size;
  logic [7:0]  prog_data, status;

  int nt = 0, nf = 0;
  int ers_n = 0, prg_n = 0, busy_n = 0;
  logic [19:0] ers_b, ers_s, prg_a;
  logic [7:0]  prg_d;

  bbflash_ctrl #(.T_PROG(TP), .T_ERS_SMALL(TES), .T_ERS_MAIN(TEM)) uut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (erase_stb) begin ers_n++; ers_b = erase_base; ers_s = erase_size; end
    if (prog_stb)  begin prg_n++; prg_a = prog_addr; prg_d = prog_data; end
    if (status[7] === 1'b0) busy_n++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nt++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bsize(int i);
    if (i == 0) return 16384;
    if (i < 3) return 8192;
    if (i == 3) return 98304;
    return 131072;
  endfunction

  task automatic ref_blk(input logic [19:0] a, input logic top,
                         output logic [19:0] base, output logic [19:0] size, output int kind);
    int p, cb;
    p = top ? (20'hFFFFF - a) : a;
    cb = 0; base = 0; size = 0; kind = 0;
    for (int i = 0; i < 11; i++) begin
      if (p >= cb && p < cb + bsize(i)) begin
        size = 20'(bsize(i));
        base = top ? 20'(20'hFFFFF - (cb + bsize(i) - 1)) : 20'(cb);
        kind = (i == 0) ? 0 : (i < 3) ? 1 : 2;
      end
      cb += bsize(i);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_ready();
    int g = 0;
    while (status[7] !== 1'b1 && g < 1000) begin @(negedge clk); g++; end
  endtask

  task automatic erase(logic [19:0] a);
    wr(a, 8'h20); wr(a, 8'hD0); wait_ready();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nf++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    logic [19:0] eb, es, a;
    logic [7:0] d, r;
    int kind, e0, b0, p0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset status", status, 8'h80);
    chk("R4 reset rd_status", rd_status, 0);
    chk("R8 reset strobes", {prog_stb, erase_stb}, 0);

    e0 = ers_n; b0 = busy_n;
    erase(20'h05123);
    chk("R1 param base", ers_b, 20'h04000);
    chk("R1 param size", ers_s, 20'h02000);
    chk("R3 one pulse", ers_n - e0, 1);
    chk("R6 small busy", busy_n - b0, TES);
    chk("R4 status after", status, 8'h80);
    chk("R4 status mode", rd_status, 1);
    wr(0, 8'hFF);
    @(negedge clk);
    chk("R4 array mode", rd_status, 0);
    wr(0, 8'h70);
    @(negedge clk);
    chk("R4 read status cmd", rd_status, 1);

    for (int k = 0; k < 24; k++) begin
      top_boot = 1'($urandom);
      a = 20'($urandom);
      if (k == 0) a = 20'h1FFFF;
      if (k == 1) a = 20'h20000;
      ref_blk(a, top_boot, eb, es, kind);
      e0 = ers_n; b0 = busy_n;
      erase(a);
      chk(top_boot ? "R2 base" : "R1 base", ers_b, eb);
      chk(top_boot ? "R2 size" : "R1 size", ers_s, es);
      chk("R3 count", ers_n - e0, 1);
      chk("R6 busy", busy_n - b0, (kind == 2) ? TEM : TES);
    end
    top_boot = 0;

    wp_hi = 0;
    e0 = ers_n;
    erase(20'h00010);
    chk("R5 locked no erase", ers_n - e0, 0);
    chk("R5 lock bit", status, 8'h82);
    wr(0, 8'h50);
    @(negedge clk);
    chk("R10 clear", status, 8'h80);
    p0 = prg_n;
    wr(20'h00020, 8'h40); wr(20'h00020, 8'h00);
    @(negedge clk);
    chk("R5 locked no program", prg_n - p0, 0);
    chk("R5 program lock bit", status, 8'h82);
    wr(0, 8'h50);
    rp_unlock = 1;
    e0 = ers_n;
    erase(20'h00010);
    chk("R5 unlock via rp", ers_n - e0, 1);
    chk("R5 boot base", ers_b, 20'h00000);
    rp_unlock = 0;
    top_boot = 1;
    e0 = ers_n;
    erase(20'hFFFF0);
    chk("R2 top boot locked", ers_n - e0, 0);
    wr(0, 8'h50);
    wp_hi = 1;
    e0 = ers_n;
    erase(20'hFFFF0);
    chk("R2 top boot base", ers_b, 20'hFC000);
    chk("R5 unlock via wp", ers_n - e0, 1);
    top_boot = 0;

    e0 = ers_n;
    wr(20'h40000, 8'h20); wr(20'h40000, 8'h33);
    @(negedge clk);
    chk("R9 no erase", ers_n - e0, 0);
    chk("R9 seq error", status, 8'hA0);
    wr(0, 8'h50);

    for (int k = 0; k < 16; k++) begin
      a = 20'($urandom); d = 8'($urandom); r = 8'($urandom);
      if (k == 0) r = 8'hFF;
      if (a < 20'h04000) a = a + 20'h04000;
      arr_rdata = r;
      p0 = prg_n; b0 = busy_n;
      wr(a, 8'h40); wr(a, d); wait_ready();
      chk("R12 data", prg_d, d & r);
      chk("R12 addr", prg_a, a);
      chk("R12 error bit", status[4], |(d & ~r));
      chk("R6 program busy", busy_n - b0, TP);
      wr(0, 8'h50);
    end
    arr_rdata = 8'hFF;

    vpp_ok = 0;
    e0 = ers_n;
    erase(20'h60000);
    chk("R7 refused", ers_n - e0, 0);
    chk("R7 vpp bit", status, 8'h88);
    vpp_ok = 1;
    wr(0, 8'h50);
    wr(20'h60000, 8'h20); wr(20'h60000, 8'hD0);
    repeat (5) @(negedge clk);
    vpp_ok = 0;
    @(negedge clk);
    chk("R7 abort", status, 8'h88);
    vpp_ok = 1;
    wr(0, 8'h50);

    p0 = prg_n; b0 = busy_n;
    wr(20'h07000, 8'h20); wr(20'h07000, 8'hD0);
    wr(0, 8'hFF);
    chk("R11 still status", rd_status, 1);
    wr(0, 8'h40);
    wr(0, 8'h00);
    chk("R11 no program", prg_n - p0, 0);
    wait_ready();
    chk("R11 busy kept", busy_n - b0, TES);
    chk("R11 mode kept", rd_status, 1);
    chk("R11 status clean", status, 8'h80);

    wr(20'h80000, 8'h20); wr(20'h80000, 8'hD0);
    repeat (3) @(negedge clk);
    rp_n = 0;
    @(negedge clk);
    chk("R8 powerdown status", status, 8'h80);
    chk("R8 array mode", rd_status, 0);
    rp_n = 1;
    repeat (TEM) @(negedge clk);
    chk("R8 no resume", status, 8'h80);

    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule